// File: doc/BRIEF.md
# Scan-Register Peripheral Bus Bridge

This block is a user data register that sits behind a boundary-scan port. Each completed data-register scan becomes one transaction on a small parallel peripheral bus. The scanned word has three fields. The top field names a peripheral, the middle field is an opcode, and the bottom field is a data byte. When the update strobe arrives, the bridge decodes the word and drives one chip select, together with a write or read strobe and the write data, for a single test-clock cycle.

A read cannot return its result in the scan that requested it, because the peripheral is only accessed after that scan has ended. The bridge therefore latches the peripheral's read data into a holding register. The next capture loads that data into the shift register, together with the header of the last transaction, and the following scan shifts it out. Host software issues a read and then any further scan to collect the result. The TAP state machine and instruction decoding are outside the block, which only sees the select, capture, shift and update strobes.

Top module: `scanBusBridge`

## Requirements
- R1: The register is DR_LEN bits (default 16), with fields peripheral address in bits 15:12, opcode in bits 11:8 and data in bits 7:0. On a rising test-clock edge with select and shift both high, it shifts right: serial input enters bit 15, and the serial output always shows bit 0.
- R2: A scan moves exactly DR_LEN bits. The word shifted in is the one decoded at update, and the DR_LEN bits shifted out are the captured word, least significant bit first.
- R3: On a rising edge with select and capture high, the register loads the last transaction's address and opcode into bits 15:8 and the holding register into bits 7:0.
- R4: Opcode 0x1 is a write. In the cycle after the update edge, chipSel[address] and wrStrobe are high for exactly one cycle, and wrData equals the data field.
- R5: Opcode 0x2 is a read. chipSel[address] and rdStrobe are high for exactly one cycle after the update edge. The rdData present in that cycle is stored in the holding register and is returned by the next scan.
- R6: Any opcode other than 0x1 or 0x2 produces no chip select and no strobe, but its address and opcode are still recorded as the last transaction header.
- R7: While select is low, shift, capture and update have no effect. The register and the last header keep their values, and no chip select or strobe asserts.
- R8: An asynchronous active-low reset clears the shift register, the last header, the holding register, all chip selects and both strobes.
- R9: At most one chip select is high at a time. A strobe is never high without a chip select, a chip select is never high without a strobe, and the write and read strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data in |
| sel | input | 1 | User register selected by the current instruction |
| capture | input | 1 | Capture strobe (parallel load of the register) |
| shift | input | 1 | Shift strobe |
| update | input | 1 | Update strobe (launches the bus cycle) |
| tdo | output | 1 | Serial data out, register bit 0 |
| chipSel | output | N_PERIPH (16) | One-hot peripheral chip selects |
| wrStrobe | output | 1 | Write strobe, one cycle |
| rdStrobe | output | 1 | Read strobe, one cycle |
| wrData | output | DATA_W (8) | Write data from the data field |
| rdData | input | DATA_W (8) | Read data from the selected peripheral |

## Verification
A bus cycle is due in the test-clock cycle that follows the update edge, and it lasts for that cycle only. The bus monitor samples on every falling edge and pops an expected item whenever any chip select or strobe is high, so an early, late, doubled or unexpected strobe fails. The captured word is loaded at the capture edge and appears on the serial output before the first shift edge. Each later bit appears one edge after the previous one, so the driver samples the serial output on the falling edge just before each shift edge. A read result is expected in the scan after the read, which the scoreboard models by carrying the held byte forward from the read.

// File: rtl/scanBusBridgePkg.sv
package scanBusBridgePkg;
  localparam int OP_WRITE = 1;
  localparam int OP_READ  = 2;

  typedef struct packed {
    logic capEn;
    logic shiftEn;
    logic updEn;
    logic latchRd;
  } dpCtrl_t;
endpackage

// File: rtl/scanBusDatapath.sv
module scanBusDatapath
  import scanBusBridgePkg::*;
#(
  parameter int DR_LEN = 16,
  parameter int HDR_W  = 8
) (
  input  logic                     tck,
  input  logic                     rstN,
  input  logic                     tdi,
  input  dpCtrl_t                  ctrl,
  input  logic [DR_LEN-HDR_W-1:0]  rdData,
  output logic [DR_LEN-1:0]        shiftWord,
  output logic [DR_LEN-HDR_W-1:0]  heldData,
  output logic                     tdo
);
  localparam int DATA_W = DR_LEN - HDR_W;

  logic [HDR_W-1:0] lastHdr;

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      shiftWord <= '0;
      lastHdr   <= '0;
      heldData  <= '0;
    end else begin
      if (ctrl.capEn) begin
        shiftWord <= {lastHdr, heldData};
      end else if (ctrl.shiftEn) begin
        shiftWord <= {tdi, shiftWord[DR_LEN-1:1]};
      end
      if (ctrl.updEn) begin
        lastHdr <= shiftWord[DR_LEN-1 -: HDR_W];
      end
      if (ctrl.latchRd) begin
        heldData <= rdData[DATA_W-1:0];
      end
    end
  end

  assign tdo = shiftWord[0];
endmodule

// File: rtl/scanBusControl.sv
module scanBusControl
  import scanBusBridgePkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int OP_W   = 4,
  parameter int DATA_W = 8
) (
  input  logic                  tck,
  input  logic                  rstN,
  input  logic                  sel,
  input  logic                  capture,
  input  logic                  shift,
  input  logic                  update,
  input  logic [ADDR_W-1:0]     addrField,
  input  logic [OP_W-1:0]       opField,
  input  logic [DATA_W-1:0]     dataField,
  output dpCtrl_t               ctrl,
  output logic [2**ADDR_W-1:0]  chipSel,
  output logic                  wrStrobe,
  output logic                  rdStrobe,
  output logic [DATA_W-1:0]     wrData
);
  localparam int N_PERIPH = 2**ADDR_W;

  logic                isWr;
  logic                isRd;
  logic                updEn;
  logic [N_PERIPH-1:0] csDecode;

  assign updEn = sel && update;
  assign isWr  = (opField == OP_W'(OP_WRITE));
  assign isRd  = (opField == OP_W'(OP_READ));

  for (genvar i = 0; i < N_PERIPH; i++) begin : gCsDec
    assign csDecode[i] = (addrField == ADDR_W'(i));
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      chipSel  <= '0;
      wrStrobe <= 1'b0;
      rdStrobe <= 1'b0;
      wrData   <= '0;
    end else begin
      chipSel  <= '0;
      wrStrobe <= 1'b0;
      rdStrobe <= 1'b0;
      if (updEn && (isWr || isRd)) begin
        chipSel  <= csDecode;
        wrStrobe <= isWr;
        rdStrobe <= isRd;
        wrData   <= dataField;
      end
    end
  end

  always_comb begin
    ctrl.capEn   = sel && capture;
    ctrl.shiftEn = sel && shift;
    ctrl.updEn   = updEn;
    ctrl.latchRd = rdStrobe;
  end
endmodule

// File: rtl/scanBusBridge.sv
module scanBusBridge
  import scanBusBridgePkg::*;
#(
  parameter int DR_LEN = 16,
  parameter int ADDR_W = 4,
  parameter int OP_W   = 4,
  localparam int DATA_W   = DR_LEN - ADDR_W - OP_W,
  localparam int N_PERIPH = 2**ADDR_W
) (
  input  logic                tck,
  input  logic                rstN,
  input  logic                tdi,
  input  logic                sel,
  input  logic                capture,
  input  logic                shift,
  input  logic                update,
  output logic                tdo,
  output logic [N_PERIPH-1:0] chipSel,
  output logic                wrStrobe,
  output logic                rdStrobe,
  output logic [DATA_W-1:0]   wrData,
  input  logic [DATA_W-1:0]   rdData
);
  localparam int HDR_W = ADDR_W + OP_W;

  dpCtrl_t           ctrl;
  logic [DR_LEN-1:0] shiftWord;
  logic [DATA_W-1:0] heldData;

  scanBusDatapath #(.DR_LEN(DR_LEN), .HDR_W(HDR_W)) uDatapath (
    .tck(tck), .rstN(rstN), .tdi(tdi), .ctrl(ctrl), .rdData(rdData),
    .shiftWord(shiftWord), .heldData(heldData), .tdo(tdo)
  );

  scanBusControl #(.ADDR_W(ADDR_W), .OP_W(OP_W), .DATA_W(DATA_W)) uControl (
    .tck(tck), .rstN(rstN), .sel(sel), .capture(capture), .shift(shift),
    .update(update),
    .addrField(shiftWord[DR_LEN-1 -: ADDR_W]),
    .opField(shiftWord[DR_LEN-ADDR_W-1 -: OP_W]),
    .dataField(shiftWord[DATA_W-1:0]),
    .ctrl(ctrl), .chipSel(chipSel), .wrStrobe(wrStrobe),
    .rdStrobe(rdStrobe), .wrData(wrData)
  );
endmodule

// File: rtl/scanBusBridgeChk.sv
module scanBusBridgeChk #(
  parameter int DR_LEN   = 16,
  parameter int N_PERIPH = 16,
  parameter int DATA_W   = 8
) (
  input logic                tck,
  input logic                rstN,
  input logic                tdi,
  input logic                sel,
  input logic                capture,
  input logic                shift,
  input logic                update,
  input logic [N_PERIPH-1:0] chipSel,
  input logic                wrStrobe,
  input logic                rdStrobe,
  input logic [DR_LEN-1:0]   shiftWord,
  input logic [DATA_W-1:0]   heldData
);
  AST_CS_ONEHOT: assert property (@(posedge tck) disable iff (!rstN)
    $onehot0(chipSel)) else $error("chip selects not one-hot"); // R9
  AST_STROBE_NEEDS_CS: assert property (@(posedge tck) disable iff (!rstN)
    (wrStrobe || rdStrobe) |-> (chipSel != '0)) else $error("strobe without select"); // R9
  AST_CS_NEEDS_STROBE: assert property (@(posedge tck) disable iff (!rstN)
    (chipSel != '0) |-> (wrStrobe || rdStrobe)) else $error("select without strobe"); // R9
  AST_WR_RD_EXCL: assert property (@(posedge tck) disable iff (!rstN)
    !(wrStrobe && rdStrobe)) else $error("read and write together"); // R9
  AST_STROBE_FROM_UPDATE: assert property (@(posedge tck) disable iff (!rstN)
    (wrStrobe || rdStrobe) |-> $past(sel && update)) else $error("strobe without update"); // R7
  AST_SHIFT_IN_MSB: assert property (@(posedge tck) disable iff (!rstN)
    (sel && shift && !capture) |=> (shiftWord[DR_LEN-1] == $past(tdi))) else $error("shift entry"); // R1
  AST_SEL_LOW_HOLD: assert property (@(posedge tck) disable iff (!rstN)
    !sel |=> $stable(shiftWord)) else $error("register moved with select low"); // R7
  AST_HELD_STABLE: assert property (@(posedge tck) disable iff (!rstN)
    !rdStrobe |=> $stable(heldData)) else $error("held data changed without read"); // R5
endmodule

bind scanBusBridge scanBusBridgeChk #(.DR_LEN(DR_LEN), .N_PERIPH(N_PERIPH), .DATA_W(DATA_W)) uChk (
  .tck(tck), .rstN(rstN), .tdi(tdi), .sel(sel), .capture(capture), .shift(shift),
  .update(update), .chipSel(chipSel), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe),
  .shiftWord(shiftWord), .heldData(heldData)
);

// File: tb/tb_scanBusBridge.sv
module tb_scanBusBridge;
  localparam int STATUS_ADDR = 3;

  typedef struct packed {
    logic [15:0] cs;
    logic        wr;
    logic        rd;
    logic [7:0]  d;
  } busItem_t;

  logic        tck = 1'b0;
  logic        rstN = 1'b0;
  logic        tdi = 1'b0, sel = 1'b0, capture = 1'b0, shift = 1'b0, update = 1'b0;
  logic        tdo, wrStrobe, rdStrobe;
  logic [15:0] chipSel;
  logic [7:0]  wrData, rdData;
  logic [7:0]  statusReg = 8'h00;

  int tests = 0;
  int fails = 0;

  logic [15:0] expQ[$];
  logic [15:0] actQ[$];
  string       tagQ[$];
  busItem_t    busQ[$];

  logic [7:0] lastHdrM = 8'h00;
  logic [7:0] heldM    = 8'h00;
  logic [7:0] statusM  = 8'h00;

  always #10 tck = ~tck;

  scanBusBridge dut (
    .tck(tck), .rstN(rstN), .tdi(tdi), .sel(sel), .capture(capture),
    .shift(shift), .update(update), .tdo(tdo), .chipSel(chipSel),
    .wrStrobe(wrStrobe), .rdStrobe(rdStrobe), .wrData(wrData), .rdData(rdData)
  );

  // Peripherals: a status register at STATUS_ADDR, others return 0xC0 | address
  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < 16; i++) begin
      if (chipSel[i]) rdData = (i == STATUS_ADDR) ? statusReg : (8'hC0 | 8'(i));
    end
  end

  always @(posedge tck) begin
    if (wrStrobe && chipSel[STATUS_ADDR]) statusReg <= wrData;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: one full scan; pushes expected capture word and bus item
  task automatic doScan(input logic [15:0] w, input logic s, input string tag);
    logic [15:0] got;
    logic [3:0]  a;
    logic [3:0]  op;
    a  = w[15:12];
    op = w[11:8];
    if (s) begin
      expQ.push_back({lastHdrM, heldM});
      tagQ.push_back(tag);
      if (op == 4'h1) begin
        busQ.push_back('{cs: 16'(1) << a, wr: 1'b1, rd: 1'b0, d: w[7:0]});
        if (a == 4'(STATUS_ADDR)) statusM = w[7:0];
      end else if (op == 4'h2) begin
        busQ.push_back('{cs: 16'(1) << a, wr: 1'b0, rd: 1'b1, d: w[7:0]});
        heldM = (a == 4'(STATUS_ADDR)) ? statusM : (8'hC0 | {4'h0, a});
      end
      lastHdrM = w[15:8];
    end
    @(negedge tck); sel = s; capture = 1'b1;
    @(negedge tck); capture = 1'b0; shift = 1'b1;
    for (int i = 0; i < 16; i++) begin
      tdi = w[i];
      got[i] = tdo;
      @(negedge tck);
    end
    shift = 1'b0; update = 1'b1;
    @(negedge tck); update = 1'b0;
    @(negedge tck); sel = 1'b0;
    @(negedge tck);
    if (s) actQ.push_back(got);
  endtask

  // Monitor: scan scoreboard
  initial begin
    forever begin
      wait (actQ.size() > 0);
      begin
        logic [15:0] a, e;
        string t;
        a = actQ.pop_front();
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(a == e, t, 32'(a), 32'(e));
      end
    end
  end

  // Monitor: bus cycles sampled mid-cycle
  always @(negedge tck) begin
    if (rstN && ((chipSel != 16'h0) || wrStrobe || rdStrobe)) begin
      if (busQ.size() == 0) begin
        check(1'b0, "R6/R7 unexpected bus cycle", {14'h0, wrStrobe, rdStrobe, chipSel}, 32'h0);
      end else begin
        busItem_t b;
        b = busQ.pop_front();
        check(chipSel == b.cs && wrStrobe == b.wr && rdStrobe == b.rd,
              "R4/R5 bus strobes", {14'h0, wrStrobe, rdStrobe, chipSel}, {14'h0, b.wr, b.rd, b.cs});
        if (b.wr) check(wrData == b.d, "R4 write data", 32'(wrData), 32'(b.d));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge tck);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge tck);
    check(tdo == 1'b0 && chipSel == 16'h0 && !wrStrobe && !rdStrobe, "R8 outputs in reset",
          {14'h0, wrStrobe, rdStrobe, chipSel}, 32'h0);
    rstN = 1'b1;
    @(negedge tck);
    check(tdo == 1'b0, "R8 tdo after reset", 32'(tdo), 32'h0);

    doScan(16'h3134, 1'b1, "R3 R8 first capture after reset");
    doScan(16'h3200, 1'b1, "R3 header of write");
    doScan(16'h0000, 1'b1, "R5 read of status returned next scan");
    doScan(16'h0155, 1'b1, "R6 no-op capture");
    doScan(16'hF2AA, 1'b1, "R6 header recorded without cycle");
    doScan(16'h57C3, 1'b1, "R5 read of peripheral 15");
    doScan(16'h5200, 0, "R7 ignored scan");
    doScan(16'h0000, 1'b1, "R7 register unchanged after select low");
    doScan(16'h31A5, 1'b1, "R2 header from full shift");
    doScan(16'h0281, 1'b1, "R4 write to status then R1 bit order");
    doScan(16'h3200, 1'b1, "R1 R2 read of peripheral 0");
    doScan(16'h0000, 1'b1, "R5 read of updated status");
    doScan(16'hA5F0, 1'b1, "R5 held status before reset");

    @(negedge tck); rstN = 1'b0;
    lastHdrM = 8'h00; heldM = 8'h00;
    @(negedge tck);
    check(tdo == 1'b0 && chipSel == 16'h0, "R8 async reset mid-run", {15'h0, tdo, chipSel}, 32'h0);
    rstN = 1'b1;
    doScan(16'h0000, 1'b1, "R8 capture cleared by reset");
    doScan(16'h0000, 1'b1, "R6 final capture");

    repeat (4) @(negedge tck);
    check(busQ.size() == 0, "R4/R5 missing bus cycle", 32'(busQ.size()), 32'h0);
    check(expQ.size() == 0 && actQ.size() == 0, "R2 unmatched scan", 32'(expQ.size()), 32'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule